// File: doc/BRIEF.md
# Multi-Track Seek Step Controller

This block moves a drive head across a requested number of tracks. The host writes a signed track move into a small register file. The sign sets the drive's step-direction line and the magnitude loads a remaining-step counter. Setting the start bit in the control register launches the seek. The engine then issues step pulses of a programmable width, separated by a programmable low time. Each pulse takes one from the counter, and the host can read the counter back at any time.

When the counter is empty and the final spacing interval has run out, the block clears the start bit and latches a seek-done flag. That flag drives the interrupt line only when its own mask bit and the global interrupt enable are both set. The host can clear the start bit to abort a seek. A single drive input, `drv_ready_i`, holds back new pulses while it is low. A dedicated register address loads a fixed recovery jog of several tracks in the negative direction.

Register map (3-bit address, 8-bit data):
- 0: control. Bit 7 is start, bit 0 is global interrupt enable.
- 1: a write loads the move; a read returns the remaining count.
- 2: interrupt flags. Bit 1 is seek-done. A read clears it; writes are ignored.
- 3: interrupt mask. Bit 1 masks seek-done.
- 4: pulse width.
- 5: pulse spacing.
- 6: jog. Any write loads the jog.

Top module: `seek_step_ctrl`

## Requirements
- R1: After reset, the step output is low, the direction output is high, the interrupt is low, and the control and count registers read 0. Width reads 4 and spacing reads 8.
- R2: A move write with bit 7 clear sets the direction output to 1 and loads the count with the value. A move with bit 7 set sets the direction output to 0 and loads the two's-complement magnitude, so 0x80 loads 128.
- R3: The first step pulse rises on the clock edge after the one that writes start = 1. Each pulse stays high for `width` cycles, and consecutive pulses are low for `spacing` cycles. A value of 0 acts as 1.
- R4: The count register (address 1) goes down by exactly one on each rising edge of the step output. It never rises except by a load.
- R5: Once the count is 0 and the last spacing interval has ended, the seek-done flag (address 2, bit 1) is set and the start bit reads back 0.
- R6: Starting with a count of 0 sets seek-done on the edge after the start write and issues no pulse.
- R7: The interrupt output is high only when the seek-done flag, mask bit 1 and control bit 0 are all 1.
- R8: A read of address 2 returns the flag and clears it. A seek-done event in the same cycle as that read leaves the flag set.
- R9: Clearing the start bit drives the step output low on the next edge. It stops further pulses, keeps the count and does not set seek-done.
- R10: While `drv_ready_i` is low, no new pulse begins and the count holds.
- R11: A write to address 6 sets the direction to 0 and loads a count of 5.
- R12: While the start bit is 1, writes to addresses 1 and 6 are ignored, and the direction output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears flags on address 2) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| drv_ready_i | input | 1 | Drive may accept a step when high |
| step_pulse_o | output | 1 | Step pulse to the drive |
| step_dir_o | output | 1 | Step direction, 1 = toward higher tracks |
| irq_o | output | 1 | Masked seek-done interrupt |

## Verification
A start write takes effect at one edge, and the first pulse rises at the next edge. A zero-count start raises the interrupt one edge after the write, so the bench samples on the falling edge right after the write and again one cycle later. It expects low and then high. Pulse width and spacing are measured by a falling-edge monitor that counts high and low samples, and those counts are compared with the programmed values. Abort, stall and ignored-write cases are judged at the ports after enough cycles for any stray pulse to appear: pulse count, read-back count and flag.

// File: rtl/seek_step_pkg.sv
package seek_step_pkg;

  localparam int unsigned ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MOVE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IFLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_IMASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_WIDTH = 3'd4;
  localparam logic [ADDR_W-1:0] A_GAP   = 3'd5;
  localparam logic [ADDR_W-1:0] A_JOG   = 3'd6;

  // bit positions inside control / interrupt registers
  localparam int unsigned GO_BIT   = 7;
  localparam int unsigned GIE_BIT  = 0;
  localparam int unsigned DONE_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } step_state_e;

endpackage

// File: rtl/seek_step_regs.sv
module seek_step_regs
  import seek_step_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned JOG_STEPS = 5,
  parameter int unsigned RST_WIDTH = 4,
  parameter int unsigned RST_GAP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              done_evt_i,
  input  logic              flag_i,
  input  logic [DATA_W-1:0] count_i,
  output logic              go_o,
  output logic              gie_o,
  output logic              mask_o,
  output logic [DATA_W-1:0] width_o,
  output logic [DATA_W-1:0] gap_o,
  output logic              load_o,
  output logic              load_dir_o,
  output logic [DATA_W-1:0] load_cnt_o,
  output logic              rd_clr_o
);

  localparam logic [DATA_W-1:0] JOG_CNT = DATA_W'(JOG_STEPS);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  // direction of a signed move: 1 = positive / zero
  function automatic logic move_dir(input logic [DATA_W-1:0] mv);
    return ~mv[DATA_W-1];
  endfunction

  // unsigned magnitude of a signed move
  function automatic logic [DATA_W-1:0] move_mag(input logic [DATA_W-1:0] mv);
    return mv[DATA_W-1] ? (~mv + ONE) : mv;
  endfunction

  logic go_q, gie_q, mask_q;
  logic [DATA_W-1:0] width_q, gap_q;
  logic wr_ctrl, wr_move, wr_jog, wr_mask, wr_width, wr_gap;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_move  = wr_en_i && (addr_i == A_MOVE);
  assign wr_jog   = wr_en_i && (addr_i == A_JOG);
  assign wr_mask  = wr_en_i && (addr_i == A_IMASK);
  assign wr_width = wr_en_i && (addr_i == A_WIDTH);
  assign wr_gap   = wr_en_i && (addr_i == A_GAP);

  // move and jog loads are blocked while a seek is active
  assign load_o     = (wr_move || wr_jog) && !go_q;
  assign load_dir_o = wr_jog ? 1'b0 : move_dir(wdata_i);
  assign load_cnt_o = wr_jog ? JOG_CNT : move_mag(wdata_i);
  assign rd_clr_o   = rd_en_i && (addr_i == A_IFLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      gie_q   <= 1'b0;
      mask_q  <= 1'b0;
      width_q <= DATA_W'(RST_WIDTH);
      gap_q   <= DATA_W'(RST_GAP);
    end else begin
      if (wr_ctrl) begin
        go_q  <= wdata_i[GO_BIT];
        gie_q <= wdata_i[GIE_BIT];
      end else if (done_evt_i) begin
        go_q <= 1'b0;
      end
      if (wr_mask)  mask_q  <= wdata_i[DONE_BIT];
      if (wr_width) width_q <= wdata_i;
      if (wr_gap)   gap_q   <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[GO_BIT]  = go_q;
        rdata_o[GIE_BIT] = gie_q;
      end
      A_MOVE:  rdata_o = count_i;
      A_IFLAG: rdata_o[DONE_BIT] = flag_i;
      A_IMASK: rdata_o[DONE_BIT] = mask_q;
      A_WIDTH: rdata_o = width_q;
      A_GAP:   rdata_o = gap_q;
      default: rdata_o = '0;
    endcase
  end

  assign go_o    = go_q;
  assign gie_o   = gie_q;
  assign mask_o  = mask_q;
  assign width_o = width_q;
  assign gap_o   = gap_q;

endmodule

// File: rtl/seek_step_engine.sv
module seek_step_engine
  import seek_step_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              ready_i,
  input  logic              load_i,
  input  logic              load_dir_i,
  input  logic [DATA_W-1:0] load_cnt_i,
  input  logic [DATA_W-1:0] width_i,
  input  logic [DATA_W-1:0] gap_i,
  output logic              step_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] count_o,
  output logic              done_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  step_state_e state_q;
  logic [DATA_W-1:0] count_q, wcnt_q, gcnt_q;
  logic step_q, dir_q;
  logic fire;

  // a new pulse may start when running, steps remain and the drive is ready
  assign fire   = go_i && ready_i && (count_q != '0);
  assign done_o = (state_q == ST_IDLE) && go_i && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 1'b0;
      dir_q   <= 1'b1;
      count_q <= '0;
      wcnt_q  <= '0;
      gcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            state_q <= ST_PULSE;
            step_q  <= 1'b1;
            count_q <= count_q - ONE;
            wcnt_q  <= width_i;
          end
        end
        ST_PULSE: begin
          if (!go_i) begin
            state_q <= ST_IDLE;
            step_q  <= 1'b0;
          end else if (wcnt_q <= ONE) begin
            state_q <= ST_GAP;
            step_q  <= 1'b0;
            gcnt_q  <= gap_i;
          end else begin
            wcnt_q <= wcnt_q - ONE;
          end
        end
        ST_GAP: begin
          if (!go_i) begin
            state_q <= ST_IDLE;
          end else if (gcnt_q <= ONE) begin
            if (fire) begin
              state_q <= ST_PULSE;
              step_q  <= 1'b1;
              count_q <= count_q - ONE;
              wcnt_q  <= width_i;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            gcnt_q <= gcnt_q - ONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          step_q  <= 1'b0;
        end
      endcase
      // loads are only accepted while stopped, so they never meet a decrement
      if (load_i) begin
        dir_q   <= load_dir_i;
        count_q <= load_cnt_i;
      end
    end
  end

  assign step_o  = step_q;
  assign dir_o   = dir_q;
  assign count_o = count_q;

endmodule

// File: rtl/seek_step_irq.sv
module seek_step_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt_i,
  input  logic rd_clr_i,
  input  logic mask_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;

  // a new event wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (done_evt_i) flag_q <= 1'b1;
    else if (rd_clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i & gie_i;

endmodule

// File: rtl/seek_step_ctrl.sv
module seek_step_ctrl
  import seek_step_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned JOG_STEPS = 5,
  parameter int unsigned RST_WIDTH = 4,
  parameter int unsigned RST_GAP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              drv_ready_i,
  output logic              step_pulse_o,
  output logic              step_dir_o,
  output logic              irq_o
);

  // internal events, named for the checker
  logic              done_evt;
  logic              go, gie, mask, flag;
  logic              load, load_dir, rd_clr;
  logic [DATA_W-1:0] load_cnt, width, gap, count;

  seek_step_regs #(
    .DATA_W   (DATA_W),
    .JOG_STEPS(JOG_STEPS),
    .RST_WIDTH(RST_WIDTH),
    .RST_GAP  (RST_GAP)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_i),
    .rd_en_i   (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .done_evt_i(done_evt),
    .flag_i    (flag),
    .count_i   (count),
    .go_o      (go),
    .gie_o     (gie),
    .mask_o    (mask),
    .width_o   (width),
    .gap_o     (gap),
    .load_o    (load),
    .load_dir_o(load_dir),
    .load_cnt_o(load_cnt),
    .rd_clr_o  (rd_clr)
  );

  seek_step_engine #(.DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .ready_i   (drv_ready_i),
    .load_i    (load),
    .load_dir_i(load_dir),
    .load_cnt_i(load_cnt),
    .width_i   (width),
    .gap_i     (gap),
    .step_o    (step_pulse_o),
    .dir_o     (step_dir_o),
    .count_o   (count),
    .done_o    (done_evt)
  );

  seek_step_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt_i(done_evt),
    .rd_clr_i  (rd_clr),
    .mask_i    (mask),
    .gie_i     (gie),
    .flag_o    (flag),
    .irq_o     (irq_o)
  );

endmodule

// File: rtl/seek_step_ctrl_chk.sv
module seek_step_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              gie,
  input logic              load,
  input logic              done_evt,
  input logic              flag,
  input logic [DATA_W-1:0] count,
  input logic              drv_ready_i,
  input logic              step_pulse_o,
  input logic              step_dir_o,
  input logic              irq_o
);

  assert_count_per_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_pulse_o) |-> (count == DATA_W'($past(count) - 1'b1)));

  assert_count_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count <= $past(count)));

  assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flag);

  assert_gie_gates_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_o);

  assert_abort_drops_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !step_pulse_o);

  assert_stall_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_ready_i && !step_pulse_o) |=> !step_pulse_o);

  assert_dir_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go)) |-> $stable(step_dir_o));

endmodule

bind seek_step_ctrl seek_step_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .go          (go),
  .gie         (gie),
  .load        (load),
  .done_evt    (done_evt),
  .flag        (flag),
  .count       (count),
  .drv_ready_i (drv_ready_i),
  .step_pulse_o(step_pulse_o),
  .step_dir_o  (step_dir_o),
  .irq_o       (irq_o)
);

// File: tb/seek_step_ctrl_test.sv
`timescale 1ns/1ps
module seek_step_ctrl_test;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic drv_ready = 1'b1;
  logic step_pulse, step_dir, irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  // pulse monitor
  int pulses = 0, hi_len = 0, lo_len = 0;
  int hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  bit seen = 0, prev_step = 0;

  always #10 clk = ~clk;

  seek_step_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .drv_ready_i(drv_ready),
    .step_pulse_o(step_pulse), .step_dir_o(step_dir), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (step_pulse) begin
      if (!prev_step) begin
        pulses++;
        if (seen) begin
          if (lo_min == 0 || lo_len < lo_min) lo_min = lo_len;
          if (lo_len > lo_max) lo_max = lo_len;
        end
        seen = 1;
        hi_len = 1;
      end else hi_len++;
    end else begin
      if (prev_step) begin
        if (hi_min == 0 || hi_len < hi_min) hi_min = hi_len;
        if (hi_len > hi_max) hi_max = hi_len;
        lo_len = 1;
      end else lo_len++;
    end
    prev_step = step_pulse;
  end

  task automatic clear_mon();
    pulses = 0; hi_min = 0; hi_max = 0; lo_min = 0; lo_max = 0; seen = 0;
  endtask

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(input int max_cyc, input string req);
    int n = 0;
    while (!irq && n < max_cyc) begin
      @(negedge clk);
      n++;
    end
    check_eq(req, "irq after seek", int'(irq), 1);
  endtask

  task automatic clear_flag();
    int d;
    rd(3'd2, d);
  endtask

  task automatic t_reset();
    int d;
    check_eq("R1", "step after reset", int'(step_pulse), 0);
    check_eq("R1", "dir after reset", int'(step_dir), 1);
    check_eq("R1", "irq after reset", int'(irq), 0);
    rd(3'd0, d); check_eq("R1", "control", d, 0);
    rd(3'd1, d); check_eq("R1", "count", d, 0);
    rd(3'd4, d); check_eq("R1", "width", d, 4);
    rd(3'd5, d); check_eq("R1", "spacing", d, 8);
  endtask

  task automatic t_positive();
    int d;
    wr(3'd4, 3); wr(3'd5, 5); wr(3'd3, 8'h02); wr(3'd1, 4);
    check_eq("R2", "dir positive", int'(step_dir), 1);
    rd(3'd1, d); check_eq("R2", "count loaded", d, 4);
    clear_mon();
    wr(3'd0, 8'h81);
    check_eq("R3", "step before first edge", int'(step_pulse), 0);
    @(negedge clk);
    check_eq("R3", "first pulse one edge after start", int'(step_pulse), 1);
    rd(3'd1, d); check_eq("R4", "count after first pulse", d, 3);
    wait_irq(200, "R5");
    check_eq("R4", "pulse total", pulses, 4);
    check_eq("R3", "width min", hi_min, 3);
    check_eq("R3", "width max", hi_max, 3);
    check_eq("R3", "spacing min", lo_min, 5);
    check_eq("R3", "spacing max", lo_max, 5);
    rd(3'd0, d); check_eq("R5", "start bit cleared", d, 8'h01);
    rd(3'd1, d); check_eq("R5", "count empty", d, 0);
    rd(3'd2, d); check_eq("R8", "flag read", d, 8'h02);
    rd(3'd2, d); check_eq("R8", "flag cleared by read", d, 0);
    check_eq("R8", "irq after clear", int'(irq), 0);
  endtask

  task automatic t_negative();
    int d;
    wr(3'd4, 1); wr(3'd5, 1); wr(3'd1, 8'hFD);
    check_eq("R2", "dir negative", int'(step_dir), 0);
    rd(3'd1, d); check_eq("R2", "magnitude of -3", d, 3);
    clear_mon();
    wr(3'd0, 8'h81);
    wait_irq(100, "R5");
    check_eq("R2", "pulses for -3", pulses, 3);
    check_eq("R3", "width 1", hi_max, 1);
    check_eq("R3", "spacing 1", lo_max, 1);
    clear_flag();
  endtask

  task automatic t_most_negative();
    int d;
    wr(3'd1, 8'h80);
    check_eq("R2", "dir for 0x80", int'(step_dir), 0);
    rd(3'd1, d); check_eq("R2", "magnitude of 0x80", d, 128);
    clear_mon();
    wr(3'd0, 8'h81);
    wait_irq(1000, "R5");
    check_eq("R2", "pulses for 0x80", pulses, 128);
    clear_flag();
  endtask

  task automatic t_zero();
    wr(3'd1, 0);
    clear_mon();
    wr(3'd0, 8'h81);
    check_eq("R6", "irq before done edge", int'(irq), 0);
    @(negedge clk);
    check_eq("R6", "irq one edge after start", int'(irq), 1);
    repeat (5) @(negedge clk);
    check_eq("R6", "no pulse for zero move", pulses, 0);
    clear_flag();
  endtask

  task automatic t_mask();
    int d;
    wr(3'd3, 0); wr(3'd1, 0); wr(3'd0, 8'h81);
    repeat (3) @(negedge clk);
    check_eq("R7", "irq masked", int'(irq), 0);
    wr(3'd3, 8'h02);
    check_eq("R7", "irq once unmasked", int'(irq), 1);
    rd(3'd2, d); check_eq("R7", "flag under mask", d, 8'h02);
    wr(3'd0, 8'h80);
    repeat (3) @(negedge clk);
    check_eq("R7", "irq with global enable off", int'(irq), 0);
    wr(3'd0, 8'h01);
    check_eq("R7", "irq with global enable on", int'(irq), 1);
    clear_flag();
  endtask

  task automatic t_abort();
    int d, n;
    wr(3'd4, 2); wr(3'd5, 4); wr(3'd1, 10);
    clear_mon();
    wr(3'd0, 8'h81);
    n = 0;
    while (pulses < 3 && n < 200) begin @(negedge clk); n++; end
    wr(3'd0, 8'h01);
    @(negedge clk);
    check_eq("R9", "step low after abort", int'(step_pulse), 0);
    repeat (40) @(negedge clk);
    check_eq("R9", "no pulses after abort", pulses, 3);
    check_eq("R9", "irq after abort", int'(irq), 0);
    rd(3'd1, d); check_eq("R9", "count kept", d, 7);
    rd(3'd2, d); check_eq("R9", "no done flag", d, 0);
  endtask

  task automatic t_ready();
    int d;
    wr(3'd4, 1); wr(3'd5, 1);
    drv_ready = 1'b0;
    wr(3'd1, 3);
    clear_mon();
    wr(3'd0, 8'h81);
    repeat (20) @(negedge clk);
    check_eq("R10", "no pulse while not ready", pulses, 0);
    rd(3'd1, d); check_eq("R10", "count held", d, 3);
    drv_ready = 1'b1;
    wait_irq(100, "R10");
    check_eq("R10", "pulses after ready", pulses, 3);
    clear_flag();
  endtask

  task automatic t_jog();
    int d;
    wr(3'd1, 2);
    wr(3'd6, 0);
    check_eq("R11", "jog dir", int'(step_dir), 0);
    rd(3'd1, d); check_eq("R11", "jog count", d, 5);
    clear_mon();
    wr(3'd0, 8'h81);
    wait_irq(100, "R11");
    check_eq("R11", "jog pulses", pulses, 5);
    clear_flag();
  endtask

  task automatic t_ignore();
    wr(3'd4, 1); wr(3'd5, 2); wr(3'd1, 6);
    clear_mon();
    wr(3'd0, 8'h81);
    wr(3'd1, 2);
    wr(3'd6, 0);
    check_eq("R12", "dir unchanged while running", int'(step_dir), 1);
    wait_irq(200, "R12");
    check_eq("R12", "pulses unaffected by writes", pulses, 6);
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positive();
    t_negative();
    t_most_negative();
    t_zero();
    t_mask();
    t_abort();
    t_ready();
    t_jog();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule